// File: doc/BRIEF.md
# Dual-Target Prioritized Interrupt Controller

This block gathers up to 29 peripheral request lines, numbered 1 to 29, and presents them to a processor on two outputs: a normal interrupt line (IRQ) and a fast interrupt line (FIQ). Software gives every input a stage of its own. That stage holds an enable, a 4-bit priority and a target bit that routes the input to IRQ or to FIQ. Each stage also keeps a registered copy of the hardware line and a software request bit. The pending state of an input is the OR of those two, so software can raise or drop a request without the peripheral. Inputs 10 and 11 take a pair of card-interface requests. Inputs 26 and 27 take the low and high priority device function requests. Inputs 28 and 29 take two DMA channel requests. The arbitration treats them like any other input.

For each target, a prioritization stage looks only at the inputs routed to it that are pending and enabled and whose priority is above that target's threshold. It picks the one with the highest priority. A registered interrupt line and a registered winner number come out of it. Each target has a vector register. Its upper bits hold a table base written by software, and its low byte holds the winning input number times 8. An interrupt handler can therefore use the vector directly as a table address.

Access is through a plain single-cycle register bus with no handshake. A write takes effect at the clock edge where `bus_we` is high. A read is combinational from `bus_addr`. The controller never stalls the bus, so there is no back-pressure to manage. All addresses below are word addresses on `bus_addr`.

Top module: `dual_target_intc`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are 0. All configuration words, software requests, thresholds and vector registers read 0, and the pending register reads 0 while no request line is high.
- R2: Address 0 reads the pending vector, with bit i set for input i and bit 0 always 0. An input is pending when its hardware line was high at the previous clock edge, or when its software request is set. Clearing the software request does not remove a pending state that the hardware line holds.
- R3: A write to address 1 sets the software request of every input whose data bit is 1. A write to address 2 clears the software request of every input whose data bit is 1. Inputs whose data bit is 0 are unaffected. Address 1 reads back the software request vector in the same bit positions.
- R4: The enable bit only gates forwarding. A pending input that is disabled still shows in the pending register, but it never drives a target line.
- R5: The configuration word of input i is at address 32+i. Bits [3:0] hold the priority, bit 4 is the target (0 = IRQ, 1 = FIQ) and bit 5 is the enable. Other bits read 0. Address 32 belongs to no input: writes to it are ignored and it reads 0.
- R6: An input is eligible on its target when it is pending, enabled, and its priority is strictly greater than that target's threshold. A priority of 0 is therefore never forwarded.
- R7: Among the eligible inputs of one target, the highest priority wins. On equal priority, the lowest-numbered input wins.
- R8: The IRQ threshold is at address 3 and the FIQ threshold is at address 4, each 4 bits in [3:0]. Each target arbitrates only the inputs routed to it, using its own threshold.
- R9: The IRQ vector is at address 5 and the FIQ vector is at address 6. Bits [31:8] are a base that software writes. Bits [7:0] read the winning input number times 8, or 0 when no input is eligible. A target's line is high exactly when its index field is nonzero.
- R10: The target lines and the vector index fields are registered. They reflect the configuration, threshold and software request state one clock edge after that state changes, and a hardware line change two edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 29 | Hardware request lines, bit i is input i (index 1 to 29) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_o | output | 1 | Normal interrupt line to the processor |
| fiq_o | output | 1 | Fast interrupt line to the processor |

## Verification
Arbitration is swept over every input at every priority, one enabled input at a time, with alternating targets. This separates the zero-priority rule and the target routing from index and vector errors. A threshold sweep walks both masks through all 16 values against fixed priorities, which separates a strictly-greater compare from greater-or-equal. A field of equal priorities is drained one input at a time to expose tie-break order. Mixed priority and target patterns driven from a shift-register sequence cover the highest-wins search under contention. Directed steps check the hardware latch delay, the one-edge output delay, a pending state that stays while enable is off, the input-0 hole in the map and the vector base readback.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int CFG_BASE = 32;

  localparam logic [ADDR_W-1:0] ADDR_PEND     = 8'd0;
  localparam logic [ADDR_W-1:0] ADDR_SWSET    = 8'd1;
  localparam logic [ADDR_W-1:0] ADDR_SWCLR    = 8'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASK_IRQ = 8'd3;
  localparam logic [ADDR_W-1:0] ADDR_VEC_IRQ  = 8'd5;
endpackage

// File: rtl/intc_src_stage.sv
module intc_src_stage #(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              cfg_we,
  input  logic [PRIO_W+1:0] cfg_wdata,
  input  logic              sw_set,
  input  logic              sw_clr,
  output logic              en_o,
  output logic              tgt_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic              sw_o,
  output logic              pend_o
);
  logic hw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q   <= 1'b0;
      en_o   <= 1'b0;
      tgt_o  <= 1'b0;
      prio_o <= '0;
      sw_o   <= 1'b0;
    end else begin
      hw_q <= req_i;
      if (cfg_we) {en_o, tgt_o, prio_o} <= cfg_wdata;
      if (sw_set)      sw_o <= 1'b1;
      else if (sw_clr) sw_o <= 1'b0;
    end
  end

  assign pend_o = hw_q | sw_o;
endmodule

// File: rtl/intc_target_arb.sv
module intc_target_arb #(
  parameter int N_SRC  = 29,
  parameter int PRIO_W = 4,
  parameter bit TGT    = 1'b0,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SRC:1]                pend_i,
  input  logic [N_SRC:1]                en_i,
  input  logic [N_SRC:1]                tgt_i,
  input  logic [N_SRC:1][PRIO_W-1:0]    prio_i,
  input  logic [PRIO_W-1:0]             mask_i,
  output logic [IDX_W-1:0]              win_o,
  output logic                          line_o
);
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;

  // Ascending scan with strict compare: the lowest number keeps a tie.
  always_comb begin
    best_p = mask_i;
    best_i = '0;
    for (int i = 1; i <= N_SRC; i++) begin
      if (pend_i[i] && en_i[i] && (tgt_i[i] == TGT) && (prio_i[i] > best_p)) begin
        best_p = prio_i[i];
        best_i = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_o  <= '0;
      line_o <= 1'b0;
    end else begin
      win_o  <= best_i;
      line_o <= (best_i != '0);
    end
  end
endmodule

// File: rtl/dual_target_intc.sv
module dual_target_intc
  import intc_pkg::*;
#(
  parameter int N_SRC  = 29,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC:1]    req_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int IDX_W  = $clog2(N_SRC + 1);
  localparam int VIDX_W = IDX_W + 3;
  localparam int BASE_W = DATA_W - VIDX_W;

  logic [N_SRC:1]             pend_v, sw_v, en_v, tgt_v;
  logic [N_SRC:1][PRIO_W-1:0] prio_v;
  logic [PRIO_W-1:0]          mask_q [2];
  logic [BASE_W-1:0]          base_q [2];
  logic [IDX_W-1:0]           win_q  [2];
  logic [1:0]                 line_q;
  logic [PRIO_W-1:0]          mask_irq, mask_fiq;
  logic [IDX_W-1:0]           win_irq, win_fiq;

  for (genvar i = 1; i <= N_SRC; i++) begin : g_src
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_BASE + i);
    intc_src_stage #(.PRIO_W(PRIO_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i[i]),
      .cfg_we    (bus_we && (bus_addr == MY_ADDR)),
      .cfg_wdata (bus_wdata[PRIO_W+1:0]),
      .sw_set    (bus_we && (bus_addr == ADDR_SWSET) && bus_wdata[i]),
      .sw_clr    (bus_we && (bus_addr == ADDR_SWCLR) && bus_wdata[i]),
      .en_o      (en_v[i]),
      .tgt_o     (tgt_v[i]),
      .prio_o    (prio_v[i]),
      .sw_o      (sw_v[i]),
      .pend_o    (pend_v[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        mask_q[t] <= '0;
        base_q[t] <= '0;
      end
    end else if (bus_we) begin
      for (int t = 0; t < 2; t++) begin
        if (bus_addr == ADDR_MASK_IRQ + ADDR_W'(t)) mask_q[t] <= bus_wdata[PRIO_W-1:0];
        if (bus_addr == ADDR_VEC_IRQ + ADDR_W'(t))  base_q[t] <= bus_wdata[DATA_W-1:VIDX_W];
      end
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_tgt
    intc_target_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .TGT(1'(t))) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend_v),
      .en_i   (en_v),
      .tgt_i  (tgt_v),
      .prio_i (prio_v),
      .mask_i (mask_q[t]),
      .win_o  (win_q[t]),
      .line_o (line_q[t])
    );
  end

  assign irq_o    = line_q[0];
  assign fiq_o    = line_q[1];
  assign mask_irq = mask_q[0];
  assign mask_fiq = mask_q[1];
  assign win_irq  = win_q[0];
  assign win_fiq  = win_q[1];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_PEND) begin
      bus_rdata[N_SRC:0] = {pend_v, 1'b0};
    end else if (bus_addr == ADDR_SWSET) begin
      bus_rdata[N_SRC:0] = {sw_v, 1'b0};
    end
    for (int t = 0; t < 2; t++) begin
      if (bus_addr == ADDR_MASK_IRQ + ADDR_W'(t)) bus_rdata[PRIO_W-1:0] = mask_q[t];
      if (bus_addr == ADDR_VEC_IRQ + ADDR_W'(t))  bus_rdata = {base_q[t], win_q[t], 3'b000};
    end
    for (int i = 1; i <= N_SRC; i++) begin
      if (bus_addr == ADDR_W'(CFG_BASE + i))
        bus_rdata[PRIO_W+1:0] = {en_v[i], tgt_v[i], prio_v[i]};
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int N_SRC  = 29,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_SRC:1]             req_i,
  input logic                       bus_we,
  input logic [7:0]                 bus_addr,
  input logic [31:0]                bus_wdata,
  input logic [N_SRC:1]             pend_v,
  input logic [N_SRC:1]             sw_v,
  input logic [N_SRC:1]             en_v,
  input logic [N_SRC:1]             tgt_v,
  input logic [N_SRC:1][PRIO_W-1:0] prio_v,
  input logic [PRIO_W-1:0]          mask_irq,
  input logic [PRIO_W-1:0]          mask_fiq,
  input logic [IDX_W-1:0]           win_irq,
  input logic [IDX_W-1:0]           win_fiq,
  input logic                       irq_o,
  input logic                       fiq_o
);
  logic [N_SRC:1]             pend_q, en_q, tgt_q;
  logic [N_SRC:1][PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0]          mirq_q, mfiq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0; en_q <= '0; tgt_q <= '0; prio_q <= '0;
      mirq_q <= '0; mfiq_q <= '0;
    end else begin
      pend_q <= pend_v; en_q <= en_v; tgt_q <= tgt_v; prio_q <= prio_v;
      mirq_q <= mask_irq; mfiq_q <= mask_fiq;
    end
  end

  AST_IRQ_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_q[win_irq] && en_q[win_irq] && !tgt_q[win_irq])); // R8
  AST_FIQ_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (pend_q[win_fiq] && en_q[win_fiq] && tgt_q[win_fiq])); // R8
  AST_IRQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (prio_q[win_irq] > mirq_q)); // R6
  AST_FIQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (prio_q[win_fiq] > mfiq_q)); // R6
  AST_HW_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |=> ((pend_v & $past(req_i)) == $past(req_i))); // R2
  AST_SW_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'd1) |=> ((sw_v & $past(bus_wdata[N_SRC:1])) == $past(bus_wdata[N_SRC:1]))); // R3
  AST_SW_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'd2) |=> ((sw_v & $past(bus_wdata[N_SRC:1])) == '0)); // R3
endmodule

bind dual_target_intc intc_checker #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pend_v    (pend_v),
  .sw_v      (sw_v),
  .en_v      (en_v),
  .tgt_v     (tgt_v),
  .prio_v    (prio_v),
  .mask_irq  (mask_irq),
  .mask_fiq  (mask_fiq),
  .win_irq   (win_irq),
  .win_fiq   (win_fiq),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o)
);

// File: tb/dual_target_intc_test.sv
`timescale 1ns/1ps
module dual_target_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:1] req_i = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  always #2.5 clk = ~clk;

  dual_target_intc uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  localparam logic [31:0] ALL = 32'h3FFF_FFFE;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] req_m = '0;
  logic [31:0] sw_m = '0;
  int cen [30];
  int ctg [30];
  int cpr [30];
  int mask_m [2];
  logic [23:0] base_m [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(input int i, input int en, input int tg, input int pr);
    wr(8'(32 + i), {26'b0, 1'(en), 1'(tg), 4'(pr)});
    cen[i] = en; ctg[i] = tg; cpr[i] = pr;
  endtask

  task automatic sw_set(input logic [31:0] m);
    wr(8'd1, m);
    sw_m = sw_m | (m & ALL);
  endtask

  task automatic sw_clr(input logic [31:0] m);
    wr(8'd2, m);
    sw_m = sw_m & ~m;
  endtask

  function automatic int exp_win(input int t);
    int best = mask_m[t];
    int w = 0;
    for (int i = 1; i <= 29; i++) begin
      if ((req_m[i] | sw_m[i]) && cen[i] != 0 && ctg[i] == t && cpr[i] > best) begin
        best = cpr[i];
        w = i;
      end
    end
    return w;
  endfunction

  task automatic check_targets(input string tag);
    logic [31:0] d;
    for (int t = 0; t < 2; t++) begin
      int w = exp_win(t);
      chk(tag, {31'b0, (t == 0) ? irq_o : fiq_o}, {31'b0, w != 0});
      rd(8'(5 + t), d);
      chk(tag, d, {base_m[t], 8'(w * 8)});
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] lfsr;
    for (int i = 0; i < 30; i++) begin cen[i] = 0; ctg[i] = 0; cpr[i] = 0; end
    mask_m[0] = 0; mask_m[1] = 0; base_m[0] = '0; base_m[1] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'd0);
    chk("R1 fiq", {31'b0, fiq_o}, 32'd0);
    rd(8'd0, d); chk("R1 pend", d, 32'd0);
    rd(8'd1, d); chk("R1 sw", d, 32'd0);
    rd(8'd5, d); chk("R1 vec", d, 32'd0);
    rd(8'd4, d); chk("R1 mask", d, 32'd0);
    rd(8'd45, d); chk("R1 cfg", d, 32'd0);

    // R5 input 0 hole and field readback
    wr(8'd32, 32'hFFFF_FFFF);
    rd(8'd32, d); chk("R5 cfg0", d, 32'd0);
    wr(8'd35, 32'hFFFF_FFFF);
    rd(8'd35, d); chk("R5 cfg3", d, 32'h3F);
    set_cfg(3, 0, 0, 0);

    // R9 vector base readback
    wr(8'd5, 32'hABCD_E1FF); base_m[0] = 24'hABCDE1;
    wr(8'd6, 32'h1234_5600); base_m[1] = 24'h123456;
    rd(8'd5, d); chk("R9 base irq", d, 32'hABCD_E100);
    rd(8'd6, d); chk("R9 base fiq", d, 32'h1234_5600);

    // R6 single input, every priority, alternating target
    sw_set(ALL);
    rd(8'd1, d); chk("R3 sw set all", d, ALL);
    for (int i = 1; i <= 29; i++) begin
      for (int p = 0; p < 16; p++) begin
        set_cfg(i, 1, i % 2, p);
        settle();
        check_targets("R6 single");
      end
      set_cfg(i, 0, 0, 0);
    end

    // R8 threshold sweep on both targets
    set_cfg(5, 1, 0, 8);
    set_cfg(6, 1, 1, 3);
    for (int m = 0; m < 16; m++) begin
      wr(8'd3, 32'(m)); mask_m[0] = m;
      wr(8'd4, 32'(15 - m)); mask_m[1] = 15 - m;
      settle();
      rd(8'd3, d); chk("R8 mask rd", d, 32'(m));
      check_targets("R8 mask");
    end
    wr(8'd3, 32'd0); mask_m[0] = 0;
    wr(8'd4, 32'd0); mask_m[1] = 0;

    // R7 ties drained one by one
    for (int i = 1; i <= 29; i++) set_cfg(i, 1, 0, 7);
    for (int k = 1; k <= 29; k++) begin
      settle();
      check_targets("R7 tie");
      sw_clr(32'h1 << k);
      rd(8'd1, d); chk("R3 sw clr", d, sw_m);
    end
    settle();
    check_targets("R7 tie empty");

    // R7 mixed priorities and targets
    for (int i = 1; i <= 29; i++) set_cfg(i, (i % 5) != 0, (i % 3) == 0, (i * 7 + 3) % 16);
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sw_clr(32'hFFFF_FFFF);
      sw_set(lfsr);
      if (n % 10 == 0) begin
        wr(8'd3, 32'(n / 10)); mask_m[0] = n / 10;
      end
      settle();
      check_targets("R7 mixed");
    end
    wr(8'd3, 32'd0); mask_m[0] = 0;

    // R4 disabled inputs stay pending but silent
    for (int i = 1; i <= 29; i++) set_cfg(i, 0, i % 2, 15);
    sw_set(ALL);
    settle();
    rd(8'd0, d); chk("R4 pend", d, ALL);
    check_targets("R4 gated");

    // R2 hardware latch delay
    sw_clr(32'hFFFF_FFFF);
    for (int i = 1; i <= 29; i++) set_cfg(i, 0, 0, 0);
    set_cfg(12, 1, 0, 9);
    settle();
    @(negedge clk);
    req_i[12] = 1'b1; req_m[12] = 1'b1;
    @(negedge clk);
    rd(8'd0, d); chk("R2 hw pend", d, 32'h1 << 12);
    chk("R10 hw delay", {31'b0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R10 hw line", {31'b0, irq_o}, 32'd1);
    check_targets("R2 hw");
    sw_set(32'h1 << 12);
    sw_clr(32'h1 << 12);
    settle();
    rd(8'd0, d); chk("R2 hw holds", d, 32'h1 << 12);
    req_i[12] = 1'b0; req_m[12] = 1'b0;
    settle();
    rd(8'd0, d); chk("R2 hw drop", d, 32'd0);
    check_targets("R2 idle");

    // R10 one-edge output delay after a software set
    set_cfg(20, 1, 1, 4);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'd1; bus_wdata = 32'h1 << 20;
    @(negedge clk);
    bus_we = 1'b0; sw_m[20] = 1'b1;
    chk("R10 fiq not yet", {31'b0, fiq_o}, 32'd0);
    rd(8'd0, d); chk("R10 pend now", d, 32'h1 << 20);
    @(negedge clk);
    chk("R10 fiq up", {31'b0, fiq_o}, 32'd1);
    check_targets("R10 vec");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (R10 progress) actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule